// File: doc/BRIEF.md
# Mode-Configurable Shift Unit with Count Masking

This block shifts a 64-bit operand left logically, right logically or right arithmetically. It is meant for the datapath of an integer execution stage. A width select picks a 32-bit data path, which uses only the low half of the operand, or the full 64-bit path. Before the shift, the raw 8-bit count is cut down by a mask that depends on the mode. In the native modes only the low 5 bits (32-bit path) or the low 6 bits (64-bit path) of the count are used, so a large count wraps around. In the legacy mode the whole 8-bit count is used, so a large count pushes every bit out.

The shifted value, a carry bit and a zero flag are all registered and appear one clock after the inputs are sampled. The carry bit holds the last bit that left the operand. When the count after masking is zero, the operand passes through unchanged, and the carry and zero flags keep the values they had.

Top module: `shift_unit`

## Requirements
- R1: While `rst_n` is low, `res`, `cout` and `zf` are all 0.
- R2: When `wide_mode`=0 and `legacy_cnt`=0, only `shamt[4:0]` is used. The shift works on `op_a[31:0]`, and `res[63:32]` is 0.
- R3: When `wide_mode`=1 and `legacy_cnt`=0, only `shamt[5:0]` is used, and the shift works on all 64 bits.
- R4: When `legacy_cnt`=1, all 8 bits of `shamt` are used. For a count above the width, a logical shift gives `res`=0 and `cout`=0, and an arithmetic right shift gives every bit of the width equal to the sign bit, with `cout` also equal to the sign bit.
- R5: `op_sel` encoding: 00 is a logical left shift, 01 is a logical right shift, 10 and 11 are an arithmetic right shift. The arithmetic right shift fills vacated bits with the sign bit, which is bit 31 on the 32-bit path and bit 63 on the 64-bit path.
- R6: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge.
- R7: When the count after masking is zero, `res` equals the width-limited operand, and `cout` and `zf` keep their previous values.
- R8: For a nonzero count after masking, `cout` is the last bit shifted out of the width-limited operand.
- R9: For a nonzero count after masking, `zf` is 1 exactly when the width-limited result is zero.
- R10: An arithmetic right shift of 0x435cb524 with a raw count of 0x55 gives 0x21a on the 64-bit native path and 0 in legacy mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 64 | Operand to shift |
| shamt | input | 8 | Raw shift count |
| op_sel | input | 2 | Shift kind select |
| wide_mode | input | 1 | 1 selects the 64-bit path, 0 the 32-bit path |
| legacy_cnt | input | 1 | 1 uses the count without masking |
| res | output | 64 | Registered shift result |
| cout | output | 1 | Registered last bit shifted out |
| zf | output | 1 | Registered zero flag |

## Verification
The hardest situation to reach is a count that is zero only after masking, such as 0x40 on the 64-bit native path or 0x20 on the 32-bit path. There the flags must hold values that an earlier shift left behind. To reach it, the stimulus first runs a shift that sets the carry and zero flags to a known, nonzero pattern, and then sends an operand whose count has only high bits set. A reference model that shifts one bit per loop step follows the flags across every clock. Counts exactly at the width and just above it are driven in legacy mode, so that the carry taken from the last bit is told apart from the sign fill.

// File: rtl/shu_pkg.sv
package shu_pkg;
    typedef enum logic [1:0] {
        OP_SHL  = 2'b00,
        OP_SHR  = 2'b01,
        OP_SAR  = 2'b10,
        OP_SAR2 = 2'b11
    } shift_op_e;

    function automatic logic is_arith(input logic [1:0] sel);
        return sel[1];
    endfunction

    function automatic logic is_left(input logic [1:0] sel);
        return (sel == OP_SHL);
    endfunction
endpackage

// File: rtl/shu_count_mask.sv
module shu_count_mask #(
    parameter int CNT_W       = 8,
    parameter int NARROW_BITS = 5,
    parameter int WIDE_BITS   = 6
) (
    input  logic [CNT_W-1:0] raw_cnt,
    input  logic             wide,
    input  logic             legacy,
    output logic [CNT_W-1:0] eff_cnt,
    output logic             eff_zero
);
    localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'((1 << NARROW_BITS) - 1);
    localparam logic [CNT_W-1:0] WIDE_MASK   = CNT_W'((1 << WIDE_BITS) - 1);

    always_comb begin
        if (legacy)
            eff_cnt = raw_cnt;
        else if (wide)
            eff_cnt = raw_cnt & WIDE_MASK;
        else
            eff_cnt = raw_cnt & NARROW_MASK;
        eff_zero = (eff_cnt == '0);
    end
endmodule

// File: rtl/shu_shifter.sv
module shu_shifter
    import shu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        op,
    input  logic              wide,
    input  logic [CNT_W-1:0]  amt,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    localparam int HALF = DATA_W / 2;

    logic              sign_bit;
    logic [DATA_W-1:0] ext;
    logic [DATA_W:0]   rtmp;
    logic [DATA_W:0]   rsh;
    logic [DATA_W:0]   lwide;
    logic [HALF:0]     lnarrow;
    logic [DATA_W-1:0] raw_res;
    logic              raw_c;

    always_comb begin
        sign_bit = wide ? data[DATA_W-1] : data[HALF-1];
        if (wide)
            ext = data;
        else if (is_arith(op))
            ext = {{HALF{sign_bit}}, data[HALF-1:0]};
        else
            ext = {{HALF{1'b0}}, data[HALF-1:0]};

        rtmp = {ext, 1'b0};
        if (is_arith(op))
            rsh = $unsigned($signed(rtmp) >>> amt);
        else
            rsh = rtmp >> amt;

        lwide   = {1'b0, data} << amt;
        lnarrow = {1'b0, data[HALF-1:0]} << amt;

        if (is_left(op)) begin
            raw_res = wide ? lwide[DATA_W-1:0] : {{HALF{1'b0}}, lnarrow[HALF-1:0]};
            raw_c   = wide ? lwide[DATA_W] : lnarrow[HALF];
        end else begin
            raw_res = rsh[DATA_W:1];
            raw_c   = rsh[0];
        end

        result = wide ? raw_res : {{HALF{1'b0}}, raw_res[HALF-1:0]};
        carry  = raw_c;
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [CNT_W-1:0]  shamt,
    input  logic [1:0]        op_sel,
    input  logic              wide_mode,
    input  logic              legacy_cnt,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              zf
);
    localparam int HALF        = DATA_W / 2;
    localparam int NARROW_BITS = $clog2(HALF);
    localparam int WIDE_BITS   = $clog2(DATA_W);

    logic [CNT_W-1:0]  eff_cnt;
    logic              eff_zero;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic [DATA_W-1:0] lim_in;

    shu_count_mask #(
        .CNT_W(CNT_W), .NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)
    ) u_mask (
        .raw_cnt (shamt),
        .wide    (wide_mode),
        .legacy  (legacy_cnt),
        .eff_cnt (eff_cnt),
        .eff_zero(eff_zero)
    );

    shu_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .data  (op_a),
        .op    (op_sel),
        .wide  (wide_mode),
        .amt   (eff_cnt),
        .result(sh_res),
        .carry (sh_c)
    );

    assign lim_in = wide_mode ? op_a : {{HALF{1'b0}}, op_a[HALF-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res  <= '0;
            cout <= 1'b0;
            zf   <= 1'b0;
        end else if (eff_zero) begin
            res <= lim_in;
        end else begin
            res  <= sh_res;
            cout <= sh_c;
            zf   <= (sh_res == '0);
        end
    end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] op_a,
    input logic [CNT_W-1:0]  shamt,
    input logic [1:0]        op_sel,
    input logic              wide_mode,
    input logic              legacy_cnt,
    input logic [DATA_W-1:0] res,
    input logic              cout,
    input logic              zf
);
    localparam int HALF = DATA_W / 2;

    logic             cnt_is_zero;
    logic [CNT_W:0]   width_now;
    logic [DATA_W-1:0] lim_a;

    always_comb begin
        if (legacy_cnt)
            cnt_is_zero = (shamt == '0);
        else if (wide_mode)
            cnt_is_zero = (shamt % DATA_W) == 0;
        else
            cnt_is_zero = (shamt % HALF) == 0;
        width_now = wide_mode ? (CNT_W+1)'(DATA_W) : (CNT_W+1)'(HALF);
        lim_a     = wide_mode ? op_a : {{HALF{1'b0}}, op_a[HALF-1:0]};
    end

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> (res == '0 || rst_n));

    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_is_zero |=> res == $past(lim_a));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_is_zero |=> $stable(cout) && $stable(zf));

    p_upper_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |=> res[DATA_W-1:HALF] == '0);

    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_is_zero |=> zf == (res == '0));

    p_logic_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_cnt && !op_sel[1] && ({1'b0, shamt} > width_now)
        |=> res == '0 && !cout);

    p_sar_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_cnt && op_sel[1] && wide_mode && ({1'b0, shamt} >= width_now)
        |=> res == {DATA_W{$past(op_a[DATA_W-1])}} && cout == $past(op_a[DATA_W-1]));
endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .shamt(shamt), .op_sel(op_sel),
    .wide_mode(wide_mode), .legacy_cnt(legacy_cnt),
    .res(res), .cout(cout), .zf(zf)
);

// File: tb/shift_unit_bench.sv
`timescale 1ns/1ps
module shift_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [7:0]  shamt = '0;
    logic [1:0]  op_sel = '0;
    logic        wide_mode = 1'b0;
    logic        legacy_cnt = 1'b0;
    logic [63:0] res;
    logic        cout;
    logic        zf;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [63:0] m_res = '0;
    logic        m_c = 1'b0;
    logic        m_z = 1'b0;

    always #5 clk = ~clk;

    shift_unit u_shift_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .shamt(shamt), .op_sel(op_sel),
        .wide_mode(wide_mode), .legacy_cnt(legacy_cnt),
        .res(res), .cout(cout), .zf(zf)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Behavioural model: one bit per loop step
    task automatic model(input logic [63:0] a, input int cnt, input logic [1:0] op,
                         input logic w, input logic l, output string rtag);
        int width = w ? 64 : 32;
        int n = l ? cnt : (cnt % width);
        logic [63:0] v = w ? a : {32'h0, a[31:0]};
        logic sgn = v[width-1];
        logic c = 1'b0;
        if (n == 0) begin
            m_res = v;
            rtag = "R7";
            return;
        end
        for (int k = 0; k < n; k++) begin
            if (op == 2'b00) begin
                c = v[width-1];
                v = v << 1;
                if (!w) v[63:32] = '0;
            end else begin
                c = v[0];
                v = v >> 1;
                if (op[1]) v[width-1] = sgn;
            end
        end
        m_res = v;
        m_c = c;
        m_z = (v == 64'h0);
        rtag = l ? "R4" : (w ? "R3" : "R2");
    endtask

    task automatic step(input logic [63:0] a, input logic [7:0] cnt, input logic [1:0] op,
                        input logic w, input logic l);
        string rtag;
        op_a = a; shamt = cnt; op_sel = op; wide_mode = w; legacy_cnt = l;
        #1;
        // R6: nothing moves before the edge
        check64("R6 hold before edge", res, m_res);
        @(posedge clk);
        model(a, int'(cnt), op, w, l, rtag);
        @(negedge clk);
        check64(rtag, res, m_res);
        check1("R8 carry", cout, m_c);
        check1("R9 zero", zf, m_z);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check64("R1 res", res, 64'h0);
        check1("R1 cout", cout, 1'b0);
        check1("R1 zf", zf, 1'b0);
        rst_n = 1'b1;

        // R10 worked example on native 64-bit and legacy
        step(64'h435cb524, 8'h55, 2'b10, 1'b1, 1'b0);
        check64("R10 native", res, 64'h21a);
        step(64'h435cb524, 8'h55, 2'b10, 1'b1, 1'b1);
        check64("R10 legacy", res, 64'h0);

        // R5 sign fill on the 32-bit path, upper half clear
        step(64'hffff_0000_8000_0000, 8'd4, 2'b10, 1'b0, 1'b0);
        check64("R5 sar32", res, 64'h0000_0000_f800_0000);
        step(64'h8000_0000_0000_0000, 8'd4, 2'b11, 1'b1, 1'b0);
        check64("R5 sar64", res, 64'hf800_0000_0000_0000);

        // R7 count zero after masking: set flags first, then hold them
        step(64'h1, 8'd1, 2'b01, 1'b1, 1'b0);   // cout=1, zf=1
        step(64'hdead_beef_1234_5678, 8'h40, 2'b00, 1'b1, 1'b0);
        check1("R7 cout held", cout, 1'b1);
        check1("R7 zf held", zf, 1'b1);
        step(64'habcd_0000_0000_0001, 8'h20, 2'b01, 1'b0, 1'b0);
        check64("R7 pass32", res, 64'h1);

        // R4 boundaries: at the width and just above
        for (int w = 0; w < 2; w++)
            for (int op = 0; op < 3; op++)
                for (int d = -1; d <= 1; d++)
                    step(64'h8000_0001_8000_0001, 8'((w ? 64 : 32) + d),
                         2'(op), 1'(w), 1'b1);
        step(64'h8000_0000_0000_0000, 8'hff, 2'b10, 1'b1, 1'b1);
        step(64'h0000_0000_7fff_ffff, 8'hff, 2'b01, 1'b0, 1'b1);

        // R2 and R3 wrap of large counts
        step(64'h0000_0000_0000_00f0, 8'h24, 2'b00, 1'b0, 1'b0);
        step(64'h0000_0000_0000_00f0, 8'h44, 2'b00, 1'b1, 1'b0);

        // Mixed patterns
        for (int i = 0; i < 400; i++)
            step({$urandom, $urandom}, 8'($urandom), 2'($urandom),
                 1'($urandom), 1'($urandom_range(0, 3) == 0));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule